// File: doc/BRIEF.md
# Two-Buffer Single-Port Bank Controller

This block sits in front of one storage bank that has a single access port. It keeps two open-row buffers, each a full copy of one bank row. A requester issues a read or write of one 32-bit word through a valid/ready channel. The controller compares the addressed row against both buffers. A request whose row is already open completes after a short fixed latency. Otherwise the controller evicts the least recently used buffer, writes that buffer's row back to the array if it was modified, loads the requested row, and completes after a longer fixed latency.

The array is reached through a row-wide port. It has a one-cycle registered row read and a row write. Only one request is in flight at a time. Responses come back as a single-cycle pulse that carries the read word and a flag telling whether the access hit an open buffer. `MISS_LAT` must be at least 5, `HIT_LAT` at least 2, and `ROW_BYTES` at least 8.

Top module: `dual_rowbuf_bank_ctrl`

## Requirements
- R1: While reset is held and in the first idle cycle after it, `req_ready` is 1, `rsp_valid` is 0 and neither array enable is active. Both buffers are invalid after reset, so the first access always misses (`rsp_hit` = 0).
- R2: After an accepting edge (`req_valid` and `req_ready` both 1), `req_ready` stays 0 through the response cycle. `rsp_valid` is high for exactly one cycle. `req_ready` returns to 1 in the following cycle.
- R3: An access whose row is held in a valid buffer raises `rsp_valid` with `rsp_hit` = 1 at the `HIT_LAT`-th rising edge, counting the accepting edge as the first. It causes no array read and no array write.
- R4: An access whose row is in neither buffer raises `rsp_valid` with `rsp_hit` = 0 at the `MISS_LAT`-th rising edge, counting the accepting edge as the first.
- R5: The row is `req_addr[log2(ROW_BYTES) +: log2(ROWS)]` and the word is `req_addr[log2(ROW_BYTES)-1:2]`; bits 1:0 are ignored. A read returns the latest value written to that word, whether it is held in a buffer or in the array. A write changes only its own word.
- R6: On a miss, the buffer not used by the most recent access is replaced. The usage record is updated on every access, hit or miss.
- R7: On a miss whose victim buffer is valid and modified, exactly one array write occurs. It carries the victim's old row number and contents and is active in the cycle after the accepting edge. A clean or invalid victim causes no array write.
- R8: On a miss, exactly one array read of the requested row occurs, one cycle after the write-back slot. `arr_rd_data` must present that row in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, request will be taken |
| req_write | input | 1 | 1 = write word, 0 = read word |
| req_addr | input | log2(ROW_BYTES)+log2(ROWS) | Byte address within the bank |
| req_wdata | input | 32 | Write word |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_hit | output | 1 | Completion came from an open buffer |
| rsp_rdata | output | 32 | Read word (meaningful for reads) |
| arr_rd_en | output | 1 | Array row read strobe |
| arr_rd_row | output | log2(ROWS) | Row to read |
| arr_rd_data | input | ROW_BYTES*8 | Row data, one cycle after the strobe |
| arr_wr_en | output | 1 | Array row write strobe |
| arr_wr_row | output | log2(ROWS) | Row to write |
| arr_wr_data | output | ROW_BYTES*8 | Row contents written back |

## Verification
The bench builds the controller with 16-byte rows, 8 rows, a hit latency of 3 and a miss latency of 6. The short rows let a few dozen requests cover every row many times. The eight-row bank makes repeated evictions of dirty and clean buffers happen within a short run. Because the two latencies differ from the defaults and from each other, a counter that is wired to a fixed value, or that uses the wrong latency, shows up in the latency checks. Keeping the rows small also lets the bench hold its own array model and compare every read word and every written-back row.

// File: rtl/rbk_pkg.sv
package rbk_pkg;
    localparam int WORD_BITS = 32;
    localparam int WAYS      = 2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BUSY,
        ST_RESP
    } ctl_state_e;
endpackage

// File: rtl/rbk_way.sv
module rbk_way #(
    parameter int ROW_W    = 9,
    parameter int ROW_BITS = 16384,
    parameter int SEL_W    = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_en,
    input  logic [ROW_W-1:0]    load_row,
    input  logic [ROW_BITS-1:0] load_data,
    input  logic                wr_en,
    input  logic [SEL_W-1:0]    wr_sel,
    input  logic [31:0]         wr_word,
    output logic                valid_o,
    output logic                dirty_o,
    output logic [ROW_W-1:0]    tag_o,
    output logic [ROW_BITS-1:0] data_o
);
    import rbk_pkg::*;

    typedef struct packed {
        logic                valid;
        logic                dirty;
        logic [ROW_W-1:0]    tag;
        logic [ROW_BITS-1:0] data;
    } way_t;

    way_t way_d, way_q;

    always_comb begin
        way_d = way_q;
        if (load_en) begin
            way_d.valid = 1'b1;
            way_d.dirty = 1'b0;
            way_d.tag   = load_row;
            way_d.data  = load_data;
        end else if (wr_en) begin
            way_d.data[wr_sel*WORD_BITS +: WORD_BITS] = wr_word;
            way_d.dirty = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            way_q.valid <= 1'b0;
            way_q.dirty <= 1'b0;
            way_q.tag   <= '0;
            way_q.data  <= way_d.data;
        end else begin
            way_q <= way_d;
        end
    end

    assign valid_o = way_q.valid;
    assign dirty_o = way_q.dirty;
    assign tag_o   = way_q.tag;
    assign data_o  = way_q.data;
endmodule

// File: rtl/rbk_match.sv
module rbk_match #(
    parameter int WAYS  = 2,
    parameter int ROW_W = 9,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [WAYS-1:0]            way_valid,
    input  logic [WAYS-1:0][ROW_W-1:0] way_tag,
    input  logic [ROW_W-1:0]           row,
    output logic                       hit,
    output logic [WAY_W-1:0]           hit_way
);
    logic [WAYS-1:0] match;

    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign match[g] = way_valid[g] && (way_tag[g] == row);
    end

    always_comb begin
        hit     = |match;
        hit_way = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (match[i]) hit_way = WAY_W'(i);
        end
    end
endmodule

// File: rtl/dual_rowbuf_bank_ctrl.sv
module dual_rowbuf_bank_ctrl #(
    parameter int ROW_BYTES = 2048,
    parameter int ROWS      = 512,
    parameter int HIT_LAT   = 4,
    parameter int MISS_LAT  = 8,
    localparam int OFF_W    = $clog2(ROW_BYTES),
    localparam int ROW_W    = $clog2(ROWS),
    localparam int ADDR_W   = OFF_W + ROW_W,
    localparam int ROW_BITS = ROW_BYTES * 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [31:0]         req_wdata,
    output logic                rsp_valid,
    output logic                rsp_hit,
    output logic [31:0]         rsp_rdata,
    output logic                arr_rd_en,
    output logic [ROW_W-1:0]    arr_rd_row,
    input  logic [ROW_BITS-1:0] arr_rd_data,
    output logic                arr_wr_en,
    output logic [ROW_W-1:0]    arr_wr_row,
    output logic [ROW_BITS-1:0] arr_wr_data
);
    import rbk_pkg::*;

    localparam int SEL_W = OFF_W - 2;
    localparam int CNT_W = $clog2(MISS_LAT + 1);
    localparam int WAY_W = 1;

    logic [WAYS-1:0]               way_valid;
    logic [WAYS-1:0]               way_dirty;
    logic [WAYS-1:0][ROW_W-1:0]    way_tag;
    logic [WAYS-1:0][ROW_BITS-1:0] way_data;
    logic [WAYS-1:0]               load_en;
    logic [WAYS-1:0]               wr_en;
    logic                          m_hit;
    logic [WAY_W-1:0]              m_way;

    typedef struct packed {
        ctl_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic              hit;
        logic [WAY_W-1:0]  way;
        logic              write;
        logic [ROW_W-1:0]  row;
        logic [SEL_W-1:0]  sel;
        logic [31:0]       wdata;
        logic [WAY_W-1:0]  lru;
        logic [31:0]       rdata;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    rbk_match #(.WAYS(WAYS), .ROW_W(ROW_W)) u_match (
        .way_valid (way_valid),
        .way_tag   (way_tag),
        .row       (req_addr[OFF_W +: ROW_W]),
        .hit       (m_hit),
        .hit_way   (m_way)
    );

    for (genvar g = 0; g < WAYS; g++) begin : g_way
        rbk_way #(.ROW_W(ROW_W), .ROW_BITS(ROW_BITS), .SEL_W(SEL_W)) u_way (
            .clk       (clk),
            .rst_n     (rst_n),
            .load_en   (load_en[g]),
            .load_row  (ctl_q.row),
            .load_data (arr_rd_data),
            .wr_en     (wr_en[g]),
            .wr_sel    (ctl_q.sel),
            .wr_word   (ctl_q.wdata),
            .valid_o   (way_valid[g]),
            .dirty_o   (way_dirty[g]),
            .tag_o     (way_tag[g]),
            .data_o    (way_data[g])
        );
    end

    logic [CNT_W-1:0] last_cnt;
    assign last_cnt = ctl_q.hit ? CNT_W'(HIT_LAT - 1) : CNT_W'(MISS_LAT - 1);

    always_comb begin
        ctl_d   = ctl_q;
        load_en = '0;
        wr_en   = '0;
        case (ctl_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    ctl_d.st    = ST_BUSY;
                    ctl_d.cnt   = CNT_W'(1);
                    ctl_d.hit   = m_hit;
                    ctl_d.way   = m_hit ? m_way : ctl_q.lru;
                    ctl_d.write = req_write;
                    ctl_d.row   = req_addr[OFF_W +: ROW_W];
                    ctl_d.sel   = req_addr[OFF_W-1:2];
                    ctl_d.wdata = req_wdata;
                end
            end
            ST_BUSY: begin
                ctl_d.cnt = ctl_q.cnt + CNT_W'(1);
                if (!ctl_q.hit && ctl_q.cnt == CNT_W'(3)) begin
                    load_en[ctl_q.way] = 1'b1;
                end
                if (ctl_q.cnt == last_cnt) begin
                    ctl_d.st    = ST_RESP;
                    ctl_d.rdata = way_data[ctl_q.way][ctl_q.sel*WORD_BITS +: WORD_BITS];
                    ctl_d.lru   = ~ctl_q.way;
                    if (ctl_q.write) wr_en[ctl_q.way] = 1'b1;
                end
            end
            default: begin
                ctl_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.st    <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    logic miss_busy;
    assign miss_busy = (ctl_q.st == ST_BUSY) && !ctl_q.hit;

    assign req_ready   = (ctl_q.st == ST_IDLE);
    assign rsp_valid   = (ctl_q.st == ST_RESP);
    assign rsp_hit     = ctl_q.hit;
    assign rsp_rdata   = ctl_q.rdata;
    assign arr_wr_en   = miss_busy && (ctl_q.cnt == CNT_W'(1)) && way_valid[ctl_q.way]
                         && way_dirty[ctl_q.way];
    assign arr_wr_row  = way_tag[ctl_q.way];
    assign arr_wr_data = way_data[ctl_q.way];
    assign arr_rd_en   = miss_busy && (ctl_q.cnt == CNT_W'(2));
    assign arr_rd_row  = ctl_q.row;
endmodule

// File: rtl/rbk_checker.sv
module rbk_checker #(
    parameter int HIT_LAT  = 4,
    parameter int MISS_LAT = 8
) (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic rsp_valid,
    input logic rsp_hit,
    input logic arr_rd_en,
    input logic arr_wr_en
);
    localparam int CW = $clog2(MISS_LAT + 2);

    logic [CW-1:0] age_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                      age_q <= '0;
        else if (req_valid && req_ready) age_q <= CW'(1);
        else if (rsp_valid)              age_q <= '0;
        else if (age_q != '0)            age_q <= age_q + CW'(1);
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !(arr_rd_en || arr_wr_en || rsp_valid));

    assert_ready_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_rsp_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));

    assert_hit_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> (age_q == CW'(HIT_LAT)));

    assert_miss_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (age_q == CW'(MISS_LAT)));

    assert_wb_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        arr_wr_en |-> (age_q == CW'(1) && !arr_rd_en));

    assert_load_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        arr_rd_en |-> (age_q == CW'(2)));
endmodule

bind dual_rowbuf_bank_ctrl rbk_checker #(.HIT_LAT(HIT_LAT), .MISS_LAT(MISS_LAT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .arr_rd_en (arr_rd_en),
    .arr_wr_en (arr_wr_en)
);

// File: tb/sim_dual_rowbuf_bank_ctrl.sv
module sim_dual_rowbuf_bank_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int RB    = 16;
    localparam int NR    = 8;
    localparam int HL    = 3;
    localparam int ML    = 6;
    localparam int OW    = 4;
    localparam int RW    = 3;
    localparam int AW    = OW + RW;
    localparam int WD    = RB / 4;
    localparam int RBITS = RB * 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic req_ready, rsp_valid, rsp_hit;
    logic [31:0] rsp_rdata;
    logic arr_rd_en, arr_wr_en;
    logic [RW-1:0] arr_rd_row, arr_wr_row;
    logic [RBITS-1:0] arr_rd_q, arr_wr_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_rowbuf_bank_ctrl #(.ROW_BYTES(RB), .ROWS(NR), .HIT_LAT(HL), .MISS_LAT(ML)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_rdata(rsp_rdata),
        .arr_rd_en(arr_rd_en), .arr_rd_row(arr_rd_row), .arr_rd_data(arr_rd_q),
        .arr_wr_en(arr_wr_en), .arr_wr_row(arr_wr_row), .arr_wr_data(arr_wr_data)
    );

    function automatic logic [31:0] seed_word(int row, int w);
        return 32'hC0DE_0000 | 32'(row << 8) | 32'(w);
    endfunction

    // behavioural storage array
    logic [RBITS-1:0] arr [NR];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NR; r++)
                for (int w = 0; w < WD; w++)
                    arr[r][w*32 +: 32] <= seed_word(r, w);
        end else begin
            if (arr_wr_en) arr[arr_wr_row] <= arr_wr_data;
            if (arr_rd_en) arr_rd_q <= arr[arr_rd_row];
        end
    end

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] data;
        bit          is_read;
        bit          hit;
        bit          first;
        bit          exp_wr;
        int          wr_row;
        int          row;
        int          acc;
    } item_t;
    item_t sb[$];

    // reference model
    logic [31:0] ref_mem [NR*WD];
    bit ref_valid [2];
    bit ref_dirty [2];
    int ref_tag [2];
    int ref_lru = 0;
    bit first_req = 1'b1;

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_req(bit wr, int row, int w, logic [31:0] wd, logic [1:0] low);
        item_t it;
        int v;
        bit h;
        h = 1'b0;
        v = ref_lru;
        for (int k = 0; k < 2; k++)
            if (ref_valid[k] && ref_tag[k] == row) begin h = 1'b1; v = k; end
        it.hit     = h;
        it.first   = first_req;
        it.is_read = !wr;
        it.row     = row;
        it.data    = ref_mem[row*WD + w];
        it.exp_wr  = !h && ref_valid[v] && ref_dirty[v];
        it.wr_row  = ref_tag[v];
        first_req  = 1'b0;
        if (!h) begin ref_tag[v] = row; ref_valid[v] = 1'b1; ref_dirty[v] = 1'b0; end
        if (wr) begin ref_dirty[v] = 1'b1; ref_mem[row*WD + w] = wd; end
        ref_lru = 1 - v;

        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = {RW'(row), 2'(w), low};
        req_wdata = wd;
        @(negedge clk);
        it.acc    = cyc;
        req_valid = 1'b0;
        check(!req_ready, "R2", "ready after accept", int'(req_ready), 0);
        sb.push_back(it);
        while (!req_ready) @(negedge clk);
    endtask

    // monitor / scoreboard
    int wr_n = 0, rd_n = 0, wr_row_seen = 0, rd_row_seen = 0;
    bit prev_rsp = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_rsp) check(req_ready && !rsp_valid, "R2", "ready/pulse after response",
                                int'({req_ready, rsp_valid}), 2);
            prev_rsp = rsp_valid;
            if (arr_wr_en) begin wr_n++; wr_row_seen = int'(arr_wr_row); end
            if (arr_rd_en) begin rd_n++; rd_row_seen = int'(arr_rd_row); end
            if (rsp_valid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R2", "unexpected response", 1, 0);
                end else begin
                    item_t it;
                    it = sb.pop_front();
                    check(rsp_hit == it.hit, it.first ? "R1" : "R6", "hit flag",
                          int'(rsp_hit), int'(it.hit));
                    check(cyc - it.acc == (it.hit ? HL : ML) - 1, it.hit ? "R3" : "R4",
                          "latency edges", cyc - it.acc + 1, it.hit ? HL : ML);
                    if (it.is_read)
                        check(rsp_rdata == it.data, "R5", "read word", int'(rsp_rdata),
                              int'(it.data));
                    check(wr_n == int'(it.exp_wr), "R7", "write-back count", wr_n,
                          int'(it.exp_wr));
                    if (it.exp_wr && wr_n == 1)
                        check(wr_row_seen == it.wr_row, "R7", "write-back row",
                              wr_row_seen, it.wr_row);
                    check(rd_n == (it.hit ? 0 : 1), it.hit ? "R3" : "R8", "row load count",
                          rd_n, it.hit ? 0 : 1);
                    if (!it.hit && rd_n == 1)
                        check(rd_row_seen == it.row, "R8", "row load address",
                              rd_row_seen, it.row);
                end
                wr_n = 0;
                rd_n = 0;
            end
        end
    end

    initial begin
        for (int r = 0; r < NR; r++)
            for (int w = 0; w < WD; w++) ref_mem[r*WD + w] = seed_word(r, w);
        for (int k = 0; k < 2; k++) begin ref_valid[k] = 0; ref_dirty[k] = 0; ref_tag[k] = 0; end

        repeat (3) @(negedge clk);
        // R1: idle state during reset
        check(req_ready && !rsp_valid && !arr_rd_en && !arr_wr_en, "R1", "reset outputs",
              int'({req_ready, rsp_valid, arr_rd_en, arr_wr_en}), 8);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && !rsp_valid, "R1", "idle after reset",
              int'({req_ready, rsp_valid}), 2);

        do_req(0, 0, 1, '0, 2'b00);             // R1 first access misses
        do_req(0, 0, 2, '0, 2'b11);             // R3 hit, R5 low bits ignored
        do_req(1, 0, 1, 32'hAAAA_5555, 2'b01);  // write hit, buffer becomes dirty
        do_req(0, 1, 0, '0, 2'b00);             // R6 miss into empty buffer
        do_req(0, 0, 1, '0, 2'b00);             // R5 hit returns written word
        do_req(0, 2, 3, '0, 2'b00);             // R7 clean victim (row 1)
        do_req(0, 3, 0, '0, 2'b10);             // R7 dirty victim (row 0) written back
        do_req(0, 0, 1, '0, 2'b00);             // R5 word survives through array
        do_req(0, 0, 0, '0, 2'b00);             // R5 neighbour word untouched

        for (int i = 0; i < 30; i++)
            do_req(i % 3 == 0, (i * 5) % NR, i % WD, 32'h1000 + 32'(i * 7), 2'(i));
        for (int i = 0; i < 12; i++)
            do_req(i % 2 == 1, (i < 6) ? 4 : 6, i % WD, 32'h7700 + 32'(i), 2'b00);
        for (int r = 0; r < NR; r++)
            for (int w = 0; w < WD; w++) do_req(0, r, w, '0, 2'b00);

        while (sb.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule